// File: doc/BRIEF.md
# Unaligned Partial Load Engine

This block carries out the left and right partial register loads of a load/store pipeline. Both a 32-bit (word) and a 64-bit (doubleword) form are supported. A partial load takes an arbitrary byte address and the current contents of the destination register. It fetches only the bytes from that address to one boundary of the enclosing aligned word or doubleword, and overwrites the matching byte lanes of the register image. The other lanes keep their old contents. Software pairs a left and a right load to assemble an unaligned value.

The engine fetches bytes one at a time over a byte-wide request/acknowledge read port. Each read carries the caller's privilege level. When the last byte arrives, the engine presents the finished 64-bit register value together with a one-cycle completion pulse. Byte order is fixed by a parameter. It decides how the lane index is derived from the address, and whether successive bytes are fetched at rising or falling addresses. An error answer on any read abandons the operation.

Top module: `partial_load_unit`

## Requirements
- R1: The lane index is address bits [1:0] for word forms and [2:0] for doubleword forms. With `BIG_ENDIAN`=1 it is used unchanged and byte k is read from address+k. With `BIG_ENDIAN`=0 it is inverted (XOR 3 or XOR 7) and byte k is read from address−k.
- R2: A left load (`op_i[0]`=0) writes byte k into lane N−1−k, where N is 4 or 8 and lane 0 is bits [7:0]. It reads N−lane bytes in total, so lane index 0 replaces the whole word.
- R3: A right load (`op_i[0]`=1) writes byte k into lane k. It reads lane+1 bytes in total, so lane index N−1 replaces the whole word.
- R4: Register lanes that the operation does not read keep the value given on `reg_i`.
- R5: A word form (`op_i[1]`=0) returns the merged low 32 bits sign-extended from bit 31 into 64 bits. A doubleword form (`op_i[1]`=1) returns all 64 merged bits.
- R6: `rd_priv_o` carries 0 for kernel, 1 for supervisor and 2 for user. A requested value of 3 is sent as 2.
- R7: Reads go out in increasing k order, with at most one outstanding. `rd_req_o` and `rd_addr_o` hold steady until `rd_ack_i`.
- R8: An acknowledge with `rd_err_i` high ends the operation with a one-cycle `fault_o` pulse. No `done_o` pulse is given, and `result_o` is left unchanged.
- R9: `start_i` is taken only while idle. `busy_o` is high from the cycle after acceptance until the cycle of `done_o` or `fault_o`, when it is low again.
- R10: After reset the engine is idle: `busy_o`, `rd_req_o`, `done_o` and `fault_o` are low, and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken when idle) |
| op_i | input | 2 | bit0: 0 left, 1 right; bit1: 0 word, 1 doubleword |
| addr_i | input | ADDR_W | Effective byte address |
| reg_i | input | 64 | Current destination register value |
| priv_i | input | 2 | Privilege level of the access |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle abort pulse |
| result_o | output | 64 | Final register value, updated with done_o |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | ADDR_W | Byte read address |
| rd_priv_o | output | 2 | Privilege level of the read |
| rd_ack_i | input | 1 | Read answer valid |
| rd_err_i | input | 1 | Read answer is an error |
| rd_data_i | input | 8 | Read data byte |

## Verification
The checker relies on the memory side answering only while `rd_req_o` is high. It also relies on an acknowledge always arriving for each request. The bench's byte server meets both conditions: it raises `rd_ack_i` only in a cycle where it sees a request, and it answers every request in that same cycle. Byte values are a fixed function of address, so every misplaced or misordered read shows up in the merged result. A big-endian and a little-endian instance run the same stimulus side by side.

// File: rtl/pld_pkg.sv
package pld_pkg;

   typedef enum logic [1:0] {
      PRIV_KERNEL = 2'd0,
      PRIV_SUPER  = 2'd1,
      PRIV_USER   = 2'd2
   } priv_e;

   typedef struct packed {
      logic dword;
      logic right;
   } ld_op_t;

   // Levels outside the three defined ones fall back to the least privileged.
   function automatic priv_e norm_priv(input logic [1:0] p);
      case (p)
         2'd0:    return PRIV_KERNEL;
         2'd1:    return PRIV_SUPER;
         default: return PRIV_USER;
      endcase
   endfunction

endpackage

// File: rtl/pld_lane_map.sv
module pld_lane_map #(
   parameter int ADDR_W     = 32,
   parameter int LANES      = 8,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic                       dword_i,
   input  logic                       right_i,
   input  logic [$clog2(LANES)-1:0]   step_i,
   output logic [$clog2(LANES):0]     nbytes_o,
   output logic [ADDR_W-1:0]          byte_addr_o,
   output logic [$clog2(LANES)-1:0]   dest_lane_o
);
   localparam int LIDX_W = $clog2(LANES);
   localparam int CNT_W  = LIDX_W + 1;

   logic [LIDX_W-1:0] top_lane;
   logic [LIDX_W-1:0] raw_idx;
   logic [LIDX_W-1:0] lane_idx;

   assign top_lane = dword_i ? LIDX_W'(LANES - 1) : LIDX_W'(LANES / 2 - 1);
   assign raw_idx  = addr_i[LIDX_W-1:0] & top_lane;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign lane_idx    = raw_idx;
         assign byte_addr_o = addr_i + ADDR_W'(step_i);
      end else begin : g_little
         assign lane_idx    = raw_idx ^ top_lane;
         assign byte_addr_o = addr_i - ADDR_W'(step_i);
      end
   endgenerate

   assign nbytes_o    = right_i ? (CNT_W'(lane_idx) + CNT_W'(1))
                                : (CNT_W'(top_lane) - CNT_W'(lane_idx) + CNT_W'(1));
   assign dest_lane_o = right_i ? step_i : (top_lane - step_i);

endmodule

// File: rtl/pld_byte_merge.sv
module pld_byte_merge #(
   parameter int LANES = 8
) (
   input  logic [LANES*8-1:0]        img_i,
   input  logic [$clog2(LANES)-1:0]  lane_i,
   input  logic [7:0]                data_i,
   output logic [LANES*8-1:0]        img_o
);
   localparam int LIDX_W = $clog2(LANES);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign img_o[g*8 +: 8] = (lane_i == LIDX_W'(g)) ? data_i : img_i[g*8 +: 8];
      end
   endgenerate

endmodule

// File: rtl/partial_load_unit.sv
module partial_load_unit
   import pld_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int REG_W      = 64,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_W-1:0]  reg_i,
   input  logic [1:0]        priv_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fault_o,
   output logic [REG_W-1:0]  result_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [1:0]        rd_priv_o,
   input  logic              rd_ack_i,
   input  logic              rd_err_i,
   input  logic [7:0]        rd_data_i
);
   localparam int LANES  = REG_W / 8;
   localparam int LIDX_W = $clog2(LANES);
   localparam int CNT_W  = LIDX_W + 1;
   localparam int HALF_W = REG_W / 2;

   generate
      if (REG_W != 64) begin : g_bad_reg
         $error("partial_load_unit: REG_W must be 64");
      end
      if (ADDR_W < LIDX_W) begin : g_bad_addr
         $error("partial_load_unit: ADDR_W too narrow for lane index");
      end
   endgenerate

   typedef enum logic {ST_IDLE, ST_FETCH} state_e;

   state_e             state_q;
   ld_op_t             op_q;
   priv_e              priv_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [REG_W-1:0]   img_q;
   logic [REG_W-1:0]   img_next;
   logic [REG_W-1:0]   img_final;
   logic [REG_W-1:0]   result_q;
   logic [LIDX_W-1:0]  step_q;
   logic [LIDX_W-1:0]  dest_lane;
   logic [CNT_W-1:0]   nbytes;
   logic [ADDR_W-1:0]  byte_addr;
   logic               last_byte;
   logic               done_q;
   logic               fault_q;

   pld_lane_map #(
      .ADDR_W     (ADDR_W),
      .LANES      (LANES),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_map (
      .addr_i      (addr_q),
      .dword_i     (op_q.dword),
      .right_i     (op_q.right),
      .step_i      (step_q),
      .nbytes_o    (nbytes),
      .byte_addr_o (byte_addr),
      .dest_lane_o (dest_lane)
   );

   pld_byte_merge #(
      .LANES (LANES)
   ) u_merge (
      .img_i  (img_q),
      .lane_i (dest_lane),
      .data_i (rd_data_i),
      .img_o  (img_next)
   );

   assign last_byte = (CNT_W'(step_q) + CNT_W'(1)) == nbytes;
   assign img_final = op_q.dword ? img_next
                                 : {{HALF_W{img_next[HALF_W-1]}}, img_next[HALF_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= '0;
         priv_q   <= PRIV_KERNEL;
         addr_q   <= '0;
         img_q    <= '0;
         result_q <= '0;
         step_q   <= '0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  op_q    <= ld_op_t'(op_i);
                  priv_q  <= norm_priv(priv_i);
                  addr_q  <= addr_i;
                  img_q   <= reg_i;
                  step_q  <= '0;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (rd_ack_i) begin
                  if (rd_err_i) begin
                     fault_q <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     img_q <= img_next;
                     if (last_byte) begin
                        result_q <= img_final;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                     end else begin
                        step_q <= step_q + LIDX_W'(1);
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q == ST_FETCH);
   assign rd_req_o  = (state_q == ST_FETCH);
   assign rd_addr_o = byte_addr;
   assign rd_priv_o = priv_q;
   assign done_o    = done_q;
   assign fault_o   = fault_q;
   assign result_o  = result_q;

endmodule

// File: rtl/pld_checker.sv
module pld_checker #(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              fault_o,
   input logic [REG_W-1:0]  result_o,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic [1:0]        rd_priv_o,
   input logic              rd_ack_i,
   input logic              rd_err_i
);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)))
      else $error("request dropped or address moved before acknowledge"); // R7

   AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (rd_priv_o != 2'd3))
      else $error("undefined privilege level on read"); // R6

   AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_ack_i && rd_err_i) |=> (fault_o && !done_o && !busy_o))
      else $error("error answer did not abort"); // R8

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o))
      else $error("result changed without completion"); // R8

   AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fault_o))
      else $error("done and fault together"); // R8

   AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fault_o) |-> !busy_o)
      else $error("busy still high at end"); // R9

   AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> busy_o)
      else $error("read request while idle"); // R9

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o)
      else $error("start while idle not taken"); // R9

endmodule

bind partial_load_unit pld_checker #(
   .ADDR_W (ADDR_W),
   .REG_W  (REG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .fault_o   (fault_o),
   .result_o  (result_o),
   .rd_req_o  (rd_req_o),
   .rd_addr_o (rd_addr_o),
   .rd_priv_o (rd_priv_o),
   .rd_ack_i  (rd_ack_i),
   .rd_err_i  (rd_err_i)
);

// File: tb/sim_partial_load_unit.sv
module sim_partial_load_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 16;
   // {dword, right, addr[7:0]}
   localparam logic [9:0] VEC [NVEC] = '{
      {2'b00, 8'h40}, {2'b00, 8'h41}, {2'b00, 8'h42}, {2'b00, 8'h43},
      {2'b01, 8'h40}, {2'b01, 8'h41}, {2'b01, 8'h42}, {2'b01, 8'h43},
      {2'b10, 8'h48}, {2'b10, 8'h4B}, {2'b10, 8'h4F}, {2'b11, 8'h50},
      {2'b11, 8'h53}, {2'b11, 8'h57}, {2'b00, 8'h66}, {2'b01, 8'h65}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = '0;
   logic [31:0] addr = '0;
   logic [63:0] regv = '0;
   logic [1:0]  priv = '0;

   logic        busy0, done0, fault0, req0, ack0, err0;
   logic        busy1, done1, fault1, req1, ack1, err1;
   logic [63:0] res0, res1;
   logic [31:0] raddr0, raddr1;
   logic [1:0]  rpriv0, rpriv1;
   logic [7:0]  data0, data1;

   int  total = 0;
   int  fails = 0;
   int  reads0 = 0, reads1 = 0;
   logic [1:0] last_priv0 = '0;
   bit  d0, f0, d1, f1;
   bit  err_on = 0;
   logic [7:0] err_addr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   partial_load_unit #(.BIG_ENDIAN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
      .reg_i(regv), .priv_i(priv), .busy_o(busy0), .done_o(done0),
      .fault_o(fault0), .result_o(res0), .rd_req_o(req0), .rd_addr_o(raddr0),
      .rd_priv_o(rpriv0), .rd_ack_i(ack0), .rd_err_i(err0), .rd_data_i(data0));

   partial_load_unit #(.BIG_ENDIAN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
      .reg_i(regv), .priv_i(priv), .busy_o(busy1), .done_o(done1),
      .fault_o(fault1), .result_o(res1), .rd_req_o(req1), .rd_addr_o(raddr1),
      .rd_priv_o(rpriv1), .rd_ack_i(ack1), .rd_err_i(err1), .rd_data_i(data1));

   function automatic logic [7:0] mbyte(input logic [7:0] a);
      return 8'((int'(a) * 37 + 11) & 255);
   endfunction

   function automatic int exp_count(input bit be, input bit dw, input bit rt,
                                    input logic [7:0] a);
      int w = dw ? 8 : 4;
      int li = int'(a) % w;
      if (!be) li = li ^ (w - 1);
      return rt ? li + 1 : w - li;
   endfunction

   function automatic logic [63:0] model(input bit be, input bit dw, input bit rt,
                                         input logic [7:0] a, input logic [63:0] r);
      int w = dw ? 8 : 4;
      int li = int'(a) % w;
      logic [63:0] img = r;
      logic [7:0] ba;
      if (!be) li = li ^ (w - 1);
      for (int k = 0; k < w; k++) begin
         if (rt ? (li >= k) : (li <= w - 1 - k)) begin
            ba = be ? 8'(int'(a) + k) : 8'(int'(a) - k);
            if (rt) img[k*8 +: 8] = mbyte(ba);
            else    img[(w-1-k)*8 +: 8] = mbyte(ba);
         end
      end
      return dw ? img : {{32{img[31]}}, img[31:0]};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Byte server for both ports: answers every request in the cycle it is seen.
   initial begin
      ack0 = 0; err0 = 0; data0 = '0; ack1 = 0; err1 = 0; data1 = '0;
      forever begin
         @(negedge clk);
         if (done0) d0 = 1;
         if (fault0) f0 = 1;
         if (done1) d1 = 1;
         if (fault1) f1 = 1;
         if (req0) begin
            ack0 = 1; data0 = mbyte(raddr0[7:0]);
            err0 = err_on && (raddr0[7:0] == err_addr);
            reads0++; last_priv0 = rpriv0;
         end else begin
            ack0 = 0; err0 = 0;
         end
         if (req1) begin
            ack1 = 1; data1 = mbyte(raddr1[7:0]); err1 = 0; reads1++;
         end else begin
            ack1 = 0; err1 = 0;
         end
      end
   end

   task automatic launch(input logic [1:0] o, input logic [7:0] a,
                         input logic [63:0] r, input logic [1:0] p);
      @(negedge clk); #1;
      d0 = 0; f0 = 0; d1 = 0; f1 = 0; reads0 = 0; reads1 = 0;
      start = 1; op = o; addr = {24'h0, a}; regv = r; priv = p;
      @(negedge clk); #1;
      start = 0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 40 && !((d0 || f0) && (d1 || f1)); i++) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", total, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [63:0] r, saved;
      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 busy", 64'(busy0), 64'd0);
      chk("R10 req", 64'(req0), 64'd0);
      chk("R10 result", res0, 64'd0);
      chk("R10 done/fault", 64'({done0, fault0}), 64'd0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R1 R2 R3 R4 R5: vector walk on both byte orders
      for (int v = 0; v < NVEC; v++) begin
         r = 64'h0123_4567_89AB_CDEF ^ {8{8'(v * 17)}};
         launch(VEC[v][9:8], VEC[v][7:0], r, 2'd0);
         wait_end();
         chk($sformatf("R2/R3/R5 big v%0d", v), res0,
             model(1, VEC[v][9], VEC[v][8], VEC[v][7:0], r));
         chk($sformatf("R1 little v%0d", v), res1,
             model(0, VEC[v][9], VEC[v][8], VEC[v][7:0], r));
         chk($sformatf("R7 reads big v%0d", v), 64'(reads0),
             64'(exp_count(1, VEC[v][9], VEC[v][8], VEC[v][7:0])));
         chk($sformatf("R1 reads little v%0d", v), 64'(reads1),
             64'(exp_count(0, VEC[v][9], VEC[v][8], VEC[v][7:0])));
      end

      // R4: doubleword right at lane 0 (big) touches only the low lane
      r = 64'hFEDC_BA98_7654_3210;
      launch(2'b11, 8'h40, r, 2'd0);
      wait_end();
      chk("R4 upper lanes kept", res0 >> 8, r >> 8);
      chk("R3 full replace little", 64'(reads1), 64'd8);

      // R2: word left at lane 0 (big) reads all four bytes
      launch(2'b00, 8'h44, r, 2'd0);
      wait_end();
      chk("R2 full replace", 64'(reads0), 64'd4);

      // R6 privilege mapping
      launch(2'b10, 8'h40, r, 2'd3);
      wait_end();
      chk("R6 level 3 -> user", 64'(last_priv0), 64'd2);
      launch(2'b10, 8'h40, r, 2'd1);
      wait_end();
      chk("R6 supervisor", 64'(last_priv0), 64'd1);
      launch(2'b10, 8'h40, r, 2'd0);
      wait_end();
      chk("R6 kernel", 64'(last_priv0), 64'd0);

      // R8 error abort on second byte
      saved = res0;
      err_on = 1; err_addr = 8'h41;
      launch(2'b00, 8'h40, 64'h1111_2222_3333_4444, 2'd2);
      wait_end();
      chk("R8 fault pulse", 64'(f0), 64'd1);
      chk("R8 no done", 64'(d0), 64'd0);
      chk("R8 result unchanged", res0, saved);
      chk("R8 reads stop", 64'(reads0), 64'd2);
      chk("R9 idle after fault", 64'(busy0), 64'd0);
      err_on = 0;
      repeat (3) @(negedge clk);

      // R9 start while busy is ignored
      @(negedge clk); #1;
      d0 = 0; f0 = 0; d1 = 0; f1 = 0; reads0 = 0; reads1 = 0;
      r = 64'h0F0F_0F0F_7070_7070;
      start = 1; op = 2'b00; addr = 32'h40; regv = r; priv = 2'd0;
      @(negedge clk); #1;
      chk("R9 busy after start", 64'(busy0), 64'd1);
      op = 2'b11; addr = 32'h47; regv = 64'd0;
      @(negedge clk); #1;
      start = 0;
      for (int i = 0; i < 40 && !d0; i++) begin
         @(negedge clk); #1;
      end
      chk("R9 second start ignored", res0, model(1, 0, 0, 8'h40, r));
      chk("R9 read count first op", 64'(reads0), 64'd4);
      repeat (3) @(negedge clk);
      chk("R9 idle at end", 64'(busy0), 64'd0);

      summary();
      $finish;
   end

endmodule